// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer. It has an 8-bit up-counter and one control byte, and both sit on a small register bus with byte-lane strobes. Software cannot write either register with an ordinary store. A write is accepted only as a 16-bit transfer, and the high byte of that halfword must carry a key that belongs to the target register. Any other write is dropped silently, so a runaway program is unlikely to disturb the timer by accident.

While the timer is enabled, the counter steps on ticks from a prescaler. The prescaler runs on the peripheral clock and has eight divide ratios. When the counter wraps from 0xFF to 0x00, the block sets a sticky flag. In watchdog mode it also pulses a reset request for one clock. In interval mode it raises an interrupt that stays high until software clears the flag through the keyed path. The control pins are plain levels. There is no streamed data path, so no valid/ready handshake is used.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the counter and control byte read as 0x00, and `rst_req_o` and `irq_o` are low.
- R2: A write to address 0 with strobes 0011 (halfword in `bus_wdata[15:0]`) or 1100 (halfword in `bus_wdata[31:16]`) whose high byte is 0x5A loads the halfword's low byte into the counter.
- R3: A halfword write with the wrong key is ignored. Address 0 needs 0x5A and address 1 needs 0xA5.
- R4: A write with any strobe pattern other than 0011 or 1100, such as a byte (0001) or a full word (1111), changes neither register, even when it carries the correct key.
- R5: A write to address 1 with strobes 0011 or 1100 and key 0xA5 loads the control byte. The byte layout is: bit 7 enable, bit 6 mode (1 watchdog, 0 interval), bit 5 overflow flag, bits 2:0 clock select. Bits 4:3 always read 0.
- R6: While bit 7 is 0, the counter holds its value and the prescaler is held at zero.
- R7: Clock select picks the tick period in clocks: 000=1, 001=4, 010=16, 011=32, 100=64, 101=256, 110=1024, 111=4096. After a keyed write sets the enable bit, the first count happens exactly one period of clocks later.
- R8: A tick at 0xFF wraps the counter to 0x00 and sets the flag. If a counter load and a tick arrive together, the load wins.
- R9: In watchdog mode, a wrap drives `rst_req_o` high for exactly one clock, in the cycle after the wrap edge, and `irq_o` stays low.
- R10: In interval mode, a wrap sets the flag and `irq_o` follows the flag. A keyed control write with bit 5 = 0 clears the flag, and bit 5 = 1 leaves it unchanged (it never sets it). A wrap in the same cycle as a clear wins.
- R11: Reads need no key. `bus_rdata` carries the register selected by `bus_addr` in bits 7:0, and bits 31:8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access to this block |
| bus_wr | input | 1 | Write when high |
| bus_addr | input | 1 | 0 counter, 1 control byte |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, selected by bus_addr |
| rst_req_o | output | 1 | One-clock reset request on watchdog overflow |
| irq_o | output | 1 | Interval interrupt, high while the flag is set |

## Verification
The key check is tried with four kinds of write:
- halfwords on both lanes with the correct key;
- halfwords with the other register's key;
- single bytes and full words that carry the correct key.

The first kind shows that each lane's key is decoded. The other two separate a key test from a width test. Each of the eight clock-select codes is measured by counting clocks from the enabling write to the first count, which distinguishes every ratio and any off-by-one in the prescaler. Overflow is driven from 0xFE and 0xFF in both modes. This separates the one-clock reset pulse from the level interrupt, and flag clearing is checked with a 0 written to bit 5 and with a 1 written to bit 5.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 3;
  localparam int NUM_DIV = 1 << SEL_W;
  localparam int PRE_W   = 12;
  localparam int BUS_W   = 32;
  localparam int BE_W    = BUS_W / 8;
  localparam int LANES   = BUS_W / 16;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;

  // log2 of the divide ratio for each clock-select code
  function automatic int div_shift(input int code);
    case (code)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      3:       return 5;
      4:       return 6;
      5:       return 8;
      6:       return 10;
      default: return 12;
    endcase
  endfunction

  typedef struct packed {
    logic             load_cnt;
    logic             load_ctl;
    logic [CNT_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
  import kwdt_pkg::*;
(
  input  logic             sel,
  input  logic             wr,
  input  logic             addr,
  input  logic [BE_W-1:0]  be,
  input  logic [BUS_W-1:0] wdata,
  output wr_req_t          req
);
  logic [LANES-1:0] lane_hit;
  logic [15:0]      lane_dat [LANES];
  logic             any_hit;
  logic [15:0]      half;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [BE_W-1:0] MASK = BE_W'(2'b11) << (2 * l);
    assign lane_hit[l] = (be == MASK);
    assign lane_dat[l] = wdata[16*l +: 16];
  end

  always_comb begin
    half = '0;
    for (int l = 0; l < LANES; l++) begin
      half = half | (lane_dat[l] & {16{lane_hit[l]}});
    end
  end

  assign any_hit      = |lane_hit;
  assign req.load_cnt = sel & wr & any_hit & ~addr & (half[15:8] == KEY_CNT);
  assign req.load_ctl = sel & wr & any_hit &  addr & (half[15:8] == KEY_CTL);
  assign req.data     = half[CNT_W-1:0];
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    localparam int SH = div_shift(g);
    if (SH == 0) begin : g_every
      assign tap[g] = 1'b1;
    end else begin : g_div
      assign tap[g] = &pre_q[SH-1:0];
    end
  end

  assign tick = run & tap[sel];
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign wrap = tick & ~load & (&cnt);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BE_W-1:0]  bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             rst_req_o,
  output logic             irq_o
);
  wr_req_t          req;
  logic             ctl_en, ctl_wd, ctl_flag;
  logic [SEL_W-1:0] ctl_cks;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap;

  kwdt_keygate u_gate (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .req(req)
  );

  kwdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .sel(ctl_cks), .tick(tick)
  );

  kwdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(req.load_cnt), .load_val(req.data),
    .cnt(cnt_q), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_wd    <= 1'b0;
      ctl_flag  <= 1'b0;
      ctl_cks   <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= wrap & ctl_wd;
      if (req.load_ctl) begin
        ctl_en   <= req.data[7];
        ctl_wd   <= req.data[6];
        ctl_cks  <= req.data[SEL_W-1:0];
        ctl_flag <= (ctl_flag & req.data[5]) | wrap;
      end else begin
        ctl_flag <= ctl_flag | wrap;
      end
    end
  end

  assign irq_o = ctl_flag & ~ctl_wd;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) bus_rdata[7:0] = {ctl_en, ctl_wd, ctl_flag, 2'b00, ctl_cks};
    else          bus_rdata[CNT_W-1:0] = cnt_q;
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_be,
  input logic        ctl_en,
  input logic        ctl_wd,
  input logic        ctl_flag,
  input logic [2:0]  ctl_cks,
  input logic [7:0]  cnt_q,
  input logic        tick,
  input logic        ld_cnt,
  input logic        rst_req_o,
  input logic        irq_o,
  input logic [23:0] rd_upper
);
  logic bad_strobe;
  assign bad_strobe = bus_sel && bus_wr && bus_be != 4'b0011 && bus_be != 4'b1100;

  p_bad_strobe_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_strobe |=> $stable({ctl_en, ctl_wd, ctl_cks}));

  p_bad_strobe_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_strobe && !tick |=> $stable(cnt_q));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en && !ld_cnt |=> $stable(cnt_q));

  p_no_tick_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !tick);

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cnt && cnt_q != 8'hFF |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_cnt && cnt_q == 8'hFF |=> cnt_q == 8'h00 && ctl_flag);

  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> ctl_flag);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_flag);

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_upper == 24'h0);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
  .ctl_en(ctl_en), .ctl_wd(ctl_wd), .ctl_flag(ctl_flag), .ctl_cks(ctl_cks),
  .cnt_q(cnt_q), .tick(tick), .ld_cnt(req.load_cnt),
  .rst_req_o(rst_req_o), .irq_o(irq_o), .rd_upper(bus_rdata[31:8])
);

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [3:0]  bus_be = 4'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        rst_req_o, irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one bus write: driven at a falling edge, taken at the next rising edge
  task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_be = 4'b0; bus_wdata = 32'h0;
  endtask

  task automatic hw(input logic a, input logic [7:0] key, input logic [7:0] val);
    wr(a, 4'b0011, {16'h0, key, val});
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_addr = 1'b0;
  endtask

  function automatic int period_of(input int code);
    case (code)
      0: return 1;    1: return 4;    2: return 16;   3: return 32;
      4: return 64;   5: return 256;  6: return 1024; default: return 4096;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, d); chk("R1 counter", d, 32'h0);
    rd(1'b1, d); chk("R1 control", d, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_cnt_write();
    logic [31:0] d;
    hw(1'b0, 8'h5A, 8'h3C);
    rd(1'b0, d); chk("R2 low lane load", d, 32'h3C);
    wr(1'b0, 4'b1100, {8'h5A, 8'hC3, 16'hFFFF});
    rd(1'b0, d); chk("R2 high lane load", d, 32'hC3);
    rd(1'b0, d); chk("R11 upper bits zero", {d[31:8], 8'h0}, 32'h0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    hw(1'b0, 8'hA5, 8'h11);
    rd(1'b0, d); chk("R3 counter wrong key", d, 32'hC3);
    hw(1'b1, 8'h5A, 8'h47);
    rd(1'b1, d); chk("R3 control wrong key", d, 32'h0);
  endtask

  task automatic t_bad_strobe();
    logic [31:0] d;
    wr(1'b0, 4'b0001, {16'h0, 8'h5A, 8'h22});
    rd(1'b0, d); chk("R4 byte write counter", d, 32'hC3);
    wr(1'b0, 4'b1111, {16'h0, 8'h5A, 8'h22});
    rd(1'b0, d); chk("R4 word write counter", d, 32'hC3);
    wr(1'b1, 4'b1111, {16'h0, 8'hA5, 8'h47});
    rd(1'b1, d); chk("R4 word write control", d, 32'h0);
    wr(1'b1, 4'b0010, {16'h0, 8'hA5, 8'h47});
    rd(1'b1, d); chk("R4 byte write control", d, 32'h0);
  endtask

  task automatic t_ctl_write();
    logic [31:0] d;
    hw(1'b1, 8'hA5, 8'h1F);
    rd(1'b1, d); chk("R5 reserved bits read zero", d, 32'h07);
    wr(1'b1, 4'b1100, {8'hA5, 8'h42, 16'h0});
    rd(1'b1, d); chk("R5 mode and select", d, 32'h42);
    hw(1'b1, 8'hA5, 8'h00);
  endtask

  task automatic t_hold_disabled();
    logic [31:0] d;
    hw(1'b0, 8'h5A, 8'h77);
    repeat (50) @(negedge clk);
    rd(1'b0, d); chk("R6 counter holds while disabled", d, 32'h77);
  endtask

  task automatic t_ratios();
    logic [31:0] d;
    for (int s = 0; s < 8; s++) begin
      int k;
      hw(1'b0, 8'h5A, 8'h10);
      hw(1'b1, 8'hA5, 8'h80 | 8'(s));
      k = 0;
      do begin
        @(negedge clk);
        k++;
        rd(1'b0, d);
      end while (d[7:0] == 8'h10 && k < 5000);
      chk($sformatf("R7 first count for select %0d", s), k, period_of(s));
      hw(1'b1, 8'hA5, 8'h00);
    end
  endtask

  task automatic t_wd_overflow();
    logic [31:0] d;
    hw(1'b0, 8'h5A, 8'hFE);
    hw(1'b1, 8'hA5, 8'hC0);
    chk("R9 no pulse before wrap", {31'h0, rst_req_o}, 32'h0);
    @(negedge clk);
    rd(1'b0, d); chk("R8 reaches FF", d, 32'hFF);
    chk("R9 no pulse at FF", {31'h0, rst_req_o}, 32'h0);
    @(negedge clk);
    rd(1'b0, d); chk("R8 wrap to 00", d, 32'h00);
    chk("R9 pulse high", {31'h0, rst_req_o}, 32'h1);
    chk("R9 no irq in watchdog mode", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 pulse one clock only", {31'h0, rst_req_o}, 32'h0);
    rd(1'b1, d); chk("R8 flag set by wrap", d, 32'hE0);
    hw(1'b1, 8'hA5, 8'h00);
    rd(1'b1, d); chk("R10 flag cleared", d, 32'h00);
  endtask

  task automatic t_interval();
    logic [31:0] d;
    hw(1'b0, 8'h5A, 8'hFF);
    hw(1'b1, 8'hA5, 8'h80);
    chk("R10 irq low before wrap", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 irq after wrap", {31'h0, irq_o}, 32'h1);
    chk("R10 no reset pulse in interval mode", {31'h0, rst_req_o}, 32'h0);
    hw(1'b1, 8'hA5, 8'h20);
    rd(1'b1, d); chk("R10 writing 1 keeps flag", d, 32'h20);
    chk("R10 irq held", {31'h0, irq_o}, 32'h1);
    hw(1'b1, 8'hA5, 8'h00);
    rd(1'b1, d); chk("R10 writing 0 clears flag", d, 32'h00);
    chk("R10 irq dropped", {31'h0, irq_o}, 32'h0);
    hw(1'b1, 8'hA5, 8'h20);
    rd(1'b1, d); chk("R10 writing 1 does not set flag", d, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cnt_write();
    t_bad_key();
    t_bad_strobe();
    t_ctl_write();
    t_hold_disabled();
    t_ratios();
    t_wd_overflow();
    t_interval();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule